// File: doc/BRIEF.md
# One-Pulse-Per-Second Reference Tracker with Lock Detection

This block lines up an internal one-second marker with an external once-per-second reference pulse. It measures how far each reference pulse lands from the internal marker, in fine counter units. The clock runs at the fine unit rate, so one count is nominally 2.16 ns. Acquisition only starts when tracking is enabled and the host reports that the oscillator is both locked and heated.

Acquisition has four steps, in this order. First it searches for two consecutive reference pulses whose spacing is one second within a tight window. It then snaps the internal marker onto the next qualified pulse. Next, it requires a run of plausible phase measurements. Once that run succeeds it enables the external regulator and reports signed phase gates, averaged over a selectable correction interval. A lock flag rises after the phase has stayed inside the tight window for a full hour of tracked pulses.

Every threshold and duration is a parameter, so a bench can shrink the second and the hour. The regulator arithmetic and the frequency actuator sit outside this block.

Top module: `pps_tracker`

## Requirements
- R1: After reset, `realign_o`, `gate_vld_o`, `reg_en_o` and `pps_lock_o` are all low.
- R2: The reference input is synchronised by two flops. A pulse is accepted only when it stays high for at least `MIN_HI` clock cycles. A shorter pulse has no effect on acquisition. The timing point of an accepted pulse is a fixed delay after its rising edge.
- R3: Nothing is acquired unless `trk_en_i`, `unit_lock_i` and `heated_i` are all high.
- R4: While searching, the block waits for two accepted pulses spaced `SEC_CYC` cycles apart, within ±`FINE_WIN` inclusive. The accepted pulse that follows such a pair realigns the internal marker and produces a one-cycle `realign_o`. A pair outside the window causes no realignment.
- R5: Each phase value is the signed distance, in cycles, from the internal marker to the accepted pulse, wrapped into [-`SEC_CYC`/2, `SEC_CYC`/2). A positive value means the reference arrived late.
- R6: After realignment, the next `PLAUS_GATES` pulses must each have |phase| ≤ `COARSE_WIN`. When they do, `reg_en_o` rises. If any one is outside, the block returns to the search step, and the failing pulse serves as the first pulse of a new pair.
- R7: Gates are reported only while `reg_en_o` is high. `gate_o` is a two's-complement value, valid for the single cycle in which `gate_vld_o` is high. With `avg_sel_i` = 0, every tracked pulse produces one strobe, carrying its raw phase.
- R8: `avg_sel_i` values 0 to 6 select averaging intervals of 1, 16, 128, 512, 2048, 8192 and 32768 tracked pulses. One strobe is issued per interval, and its value is the floor of the phase sum divided by the interval length.
- R9: `pps_lock_o` rises after `LOCK_SECS` consecutive tracked pulses with |phase| ≤ `FINE_WIN`. A single pulse outside that window clears both the flag and the count.
- R10: If `trk_en_i`, `unit_lock_i` or `heated_i` drops, then after the next clock edge `reg_en_o` and `pps_lock_o` are low. Acquisition then starts over, from a fresh search for a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pps_i | input | 1 | External once-per-second reference pulse (asynchronous) |
| trk_en_i | input | 1 | Tracking enable |
| unit_lock_i | input | 1 | Oscillator locked qualifier |
| heated_i | input | 1 | Ovens at temperature qualifier |
| avg_sel_i | input | 3 | Averaging interval select, 0 to 6 |
| realign_o | output | 1 | One-cycle strobe when the internal marker is realigned |
| gate_vld_o | output | 1 | One-cycle strobe marking a new `gate_o` |
| gate_o | output | GATE_W | Signed averaged phase gate |
| reg_en_o | output | 1 | Regulator enable, high while tracking |
| pps_lock_o | output | 1 | Sustained-alignment lock flag |

## Verification
The bench builds the tracker with a 100-cycle second, a fine window of ±2, a coarse window of ±10, a 4-cycle minimum width, a 5-pulse lock hour and 16-bit gates. This puts every acquisition step within a few thousand cycles: the search, the realignment, the full 16-gate plausibility run and its failure path, and the lock. The pair window, the plausibility window and the lock window are each driven to both edges. Averaging states 0, 1 and 2, including their floor rounding of negative sums, are swept pulse by pulse. Expected values are computed from the offset that each pulse is placed at within its slot.

// File: rtl/pps_trk_pkg.sv
package pps_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_ALIGN,
    ST_VERIFY,
    ST_TRACK
  } trk_state_e;

  // Map a position inside the second onto a signed phase; late pulses are positive.
  function automatic longint wrap_phase(longint pos, longint period);
    return (pos < period / 2) ? pos : pos - period;
  endfunction

  // Inclusive symmetric window test.
  function automatic logic in_window(longint v, longint lim);
    return (v <= lim) && (v >= -lim);
  endfunction

  // log2 of the averaging interval for each select value.
  function automatic logic [3:0] avg_shift(logic [2:0] sel);
    case (sel)
      3'd0:    return 4'd0;
      3'd1:    return 4'd4;
      3'd2:    return 4'd7;
      3'd3:    return 4'd9;
      3'd4:    return 4'd11;
      3'd5:    return 4'd13;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pps_pulse_qual.sv
module pps_pulse_qual #(
  parameter int MIN_HI = 463
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_i,
  output logic evt_o
);
  localparam int RW = $clog2(MIN_HI + 1);

  logic          s1_q, s2_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q <= pps_i;
      s2_q <= s1_q;
      if (!s2_q)                      run_q <= '0;
      else if (run_q != RW'(MIN_HI))  run_q <= run_q + RW'(1);
    end
  end

  // Fires on the MIN_HI-th consecutive high sample, once per pulse.
  assign evt_o = s2_q && (run_q == RW'(MIN_HI - 1));

endmodule

// File: rtl/pps_sec_phase.sv
module pps_sec_phase
  import pps_trk_pkg::*;
#(
  parameter int SEC_CYC = 462962963,
  parameter int GATE_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     align_i,
  output logic signed [GATE_W-1:0] err_o
);
  localparam int PW = $clog2(SEC_CYC);

  logic [PW-1:0] pos_q;

  // The realign cycle itself is position 0 of the new second.
  always_ff @(posedge clk) begin
    if (!rst_n)                           pos_q <= '0;
    else if (align_i)                     pos_q <= PW'(1);
    else if (pos_q == PW'(SEC_CYC - 1))   pos_q <= '0;
    else                                  pos_q <= pos_q + PW'(1);
  end

  assign err_o = GATE_W'(wrap_phase(longint'(pos_q), longint'(SEC_CYC)));

endmodule

// File: rtl/pps_acq_fsm.sv
module pps_acq_fsm
  import pps_trk_pkg::*;
#(
  parameter int SEC_CYC     = 462962963,
  parameter int FINE_WIN    = 23,
  parameter int COARSE_WIN  = 231,
  parameter int PLAUS_GATES = 16,
  parameter int LOCK_SECS   = 3600,
  parameter int GATE_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_i,
  input  logic                     qual_ok_i,
  input  logic signed [GATE_W-1:0] err_i,
  output logic                     align_o,
  output logic                     pair_o,
  output logic                     vfail_o,
  output logic                     take_o,
  output logic                     track_o,
  output logic                     lock_o
);
  localparam int GMAX = 2 * SEC_CYC;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int VW   = $clog2(PLAUS_GATES + 1);
  localparam int LW   = $clog2(LOCK_SECS + 1);

  trk_state_e    state_q;
  logic [GW-1:0] gap_q;
  logic          prev_q;
  logic [VW-1:0] vcnt_q;
  logic [LW-1:0] lcnt_q;
  logic          lock_q;

  logic pair_ok, fine_ok, coarse_ok;

  always_comb begin
    pair_ok   = prev_q && in_window(longint'(gap_q) - longint'(SEC_CYC), longint'(FINE_WIN));
    fine_ok   = in_window(longint'(err_i), longint'(FINE_WIN));
    coarse_ok = in_window(longint'(err_i), longint'(COARSE_WIN));
    align_o   = qual_ok_i && evt_i && (state_q == ST_ALIGN);
    pair_o    = qual_ok_i && evt_i && (state_q == ST_SEARCH) && pair_ok;
    vfail_o   = qual_ok_i && evt_i && (state_q == ST_VERIFY) && !coarse_ok;
    take_o    = qual_ok_i && evt_i && (state_q == ST_TRACK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
      prev_q  <= 1'b0;
      vcnt_q  <= '0;
      lcnt_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (evt_i)                    gap_q <= GW'(1);
      else if (gap_q != GW'(GMAX))  gap_q <= gap_q + GW'(1);

      if (!qual_ok_i) begin
        state_q <= ST_IDLE;
        prev_q  <= 1'b0;
        vcnt_q  <= '0;
        lcnt_q  <= '0;
        lock_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            state_q <= ST_SEARCH;
            prev_q  <= 1'b0;
          end
          ST_SEARCH: if (evt_i) begin
            prev_q <= 1'b1;
            if (pair_ok) state_q <= ST_ALIGN;
          end
          ST_ALIGN: if (evt_i) begin
            state_q <= ST_VERIFY;
            vcnt_q  <= '0;
          end
          ST_VERIFY: if (evt_i) begin
            if (!coarse_ok) begin
              state_q <= ST_SEARCH;
              prev_q  <= 1'b1;
            end else if (vcnt_q == VW'(PLAUS_GATES - 1)) begin
              state_q <= ST_TRACK;
              lcnt_q  <= '0;
              lock_q  <= 1'b0;
            end else begin
              vcnt_q <= vcnt_q + VW'(1);
            end
          end
          ST_TRACK: if (evt_i) begin
            if (fine_ok) begin
              if (lcnt_q != LW'(LOCK_SECS)) lcnt_q <= lcnt_q + LW'(1);
              if (lcnt_q >= LW'(LOCK_SECS - 1)) lock_q <= 1'b1;
            end else begin
              lcnt_q <= '0;
              lock_q <= 1'b0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign track_o = (state_q == ST_TRACK);
  assign lock_o  = lock_q;

endmodule

// File: rtl/pps_gate_avg.sv
module pps_gate_avg
  import pps_trk_pkg::*;
#(
  parameter int GATE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     take_i,
  input  logic signed [GATE_W-1:0] err_i,
  input  logic [2:0]               sel_i,
  output logic                     vld_o,
  output logic signed [GATE_W-1:0] gate_o
);
  localparam int CW = 16;
  localparam int AW = GATE_W + CW;

  logic signed [AW-1:0] acc_q, err_x, sum;
  logic [CW-1:0]        cnt_q, lim;
  logic [3:0]           sh;

  always_comb begin
    sh    = avg_shift(sel_i);
    lim   = CW'((32'd1 << sh) - 32'd1);
    err_x = AW'(err_i);
    sum   = acc_q + err_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_o  <= 1'b0;
      gate_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (clear_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (take_i) begin
        if (cnt_q >= lim) begin
          gate_o <= GATE_W'(sum >>> sh);
          vld_o  <= 1'b1;
          acc_q  <= '0;
          cnt_q  <= '0;
        end else begin
          acc_q <= sum;
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pps_tracker.sv
module pps_tracker #(
  parameter int SEC_CYC     = 462962963,
  parameter int FINE_WIN    = 23,
  parameter int COARSE_WIN  = 231,
  parameter int PLAUS_GATES = 16,
  parameter int LOCK_SECS   = 3600,
  parameter int MIN_HI      = 463,
  parameter int GATE_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_pps_i,
  input  logic                     trk_en_i,
  input  logic                     unit_lock_i,
  input  logic                     heated_i,
  input  logic [2:0]               avg_sel_i,
  output logic                     realign_o,
  output logic                     gate_vld_o,
  output logic signed [GATE_W-1:0] gate_o,
  output logic                     reg_en_o,
  output logic                     pps_lock_o
);
  logic                     evt_w, align_w, pair_w, vfail_w, take_w, track_w, lock_w, qual_ok_w;
  logic signed [GATE_W-1:0] err_w;

  assign qual_ok_w = trk_en_i && unit_lock_i && heated_i;

  pps_pulse_qual #(.MIN_HI(MIN_HI)) u_qual (
    .clk(clk), .rst_n(rst_n), .pps_i(ref_pps_i), .evt_o(evt_w)
  );

  pps_sec_phase #(.SEC_CYC(SEC_CYC), .GATE_W(GATE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .align_i(align_w), .err_o(err_w)
  );

  pps_acq_fsm #(
    .SEC_CYC(SEC_CYC), .FINE_WIN(FINE_WIN), .COARSE_WIN(COARSE_WIN),
    .PLAUS_GATES(PLAUS_GATES), .LOCK_SECS(LOCK_SECS), .GATE_W(GATE_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .qual_ok_i(qual_ok_w), .err_i(err_w),
    .align_o(align_w), .pair_o(pair_w), .vfail_o(vfail_w), .take_o(take_w),
    .track_o(track_w), .lock_o(lock_w)
  );

  pps_gate_avg #(.GATE_W(GATE_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .clear_i(!track_w), .take_i(take_w), .err_i(err_w),
    .sel_i(avg_sel_i), .vld_o(gate_vld_o), .gate_o(gate_o)
  );

  assign realign_o  = align_w;
  assign reg_en_o   = track_w;
  assign pps_lock_o = lock_w;

endmodule

// File: rtl/pps_tracker_chk.sv
module pps_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic trk_en_i,
  input logic unit_lock_i,
  input logic heated_i,
  input logic evt_i,
  input logic pair_i,
  input logic vfail_i,
  input logic realign_o,
  input logic gate_vld_o,
  input logic reg_en_o,
  input logic pps_lock_o
);
  logic qual_ok;
  assign qual_ok = trk_en_i && unit_lock_i && heated_i;

  a_r10_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_ok |=> (!reg_en_o && !pps_lock_o));

  a_r9_lock_needs_track: assert property (@(posedge clk) disable iff (!rst_n)
    pps_lock_o |-> reg_en_o);

  a_r9_lock_rise_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_lock_o) |-> $past(evt_i));

  a_r6_track_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en_o) |-> $past(evt_i));

  a_r4_realign_enters_verify: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |=> !reg_en_o);

  a_r4_pair_then_no_track: assert property (@(posedge clk) disable iff (!rst_n)
    pair_i |-> (!reg_en_o && !realign_o));

  a_r6_fail_drops_nothing_on: assert property (@(posedge clk) disable iff (!rst_n)
    vfail_i |=> !reg_en_o);

  a_r7_gate_only_tracking: assert property (@(posedge clk) disable iff (!rst_n)
    gate_vld_o |-> reg_en_o);

  a_r3_realign_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |-> qual_ok);
endmodule

bind pps_tracker pps_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trk_en_i(trk_en_i), .unit_lock_i(unit_lock_i),
  .heated_i(heated_i), .evt_i(evt_w), .pair_i(pair_w), .vfail_i(vfail_w),
  .realign_o(realign_o), .gate_vld_o(gate_vld_o), .reg_en_o(reg_en_o),
  .pps_lock_o(pps_lock_o)
);

// File: tb/pps_tracker_tb.sv
module pps_tracker_tb_top;
  localparam int SEC  = 100;
  localparam int FINE = 2;
  localparam int CRS  = 10;
  localparam int LCK  = 5;
  localparam int MINW = 4;
  localparam int GW   = 16;
  localparam int BASE = 20;

  logic clk = 1'b0;
  logic rst_n, ref_pps, trk_en, ulk, heat;
  logic [2:0] sel;
  logic realign_o, gate_vld_o, reg_en_o, pps_lock_o;
  logic signed [GW-1:0] gate_o;

  int checks = 0, fails = 0;
  int rcnt = 0, gn = 0;
  int gq [0:511];
  bit done = 0;

  always #5 clk = ~clk;

  pps_tracker #(
    .SEC_CYC(SEC), .FINE_WIN(FINE), .COARSE_WIN(CRS), .PLAUS_GATES(16),
    .LOCK_SECS(LCK), .MIN_HI(MINW), .GATE_W(GW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pps_i(ref_pps), .trk_en_i(trk_en),
    .unit_lock_i(ulk), .heated_i(heat), .avg_sel_i(sel), .realign_o(realign_o),
    .gate_vld_o(gate_vld_o), .gate_o(gate_o), .reg_en_o(reg_en_o), .pps_lock_o(pps_lock_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (realign_o) rcnt++;
      if (gate_vld_o && gn < 512) begin
        gq[gn] = int'(gate_o);
        gn++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One slot is exactly SEC cycles; the pulse rises BASE+off cycles into it.
  task automatic slot(int off, int w);
    repeat (BASE + off) @(negedge clk);
    ref_pps = 1'b1;
    repeat (w) @(negedge clk);
    ref_pps = 1'b0;
    repeat (SEC - BASE - off - w) @(negedge clk);
  endtask

  function automatic int floor_div(int s, int n);
    if (s >= 0) return s / n;
    return -((-s + n - 1) / n);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) act=0 exp=1");
    finish_run();
  end

  initial begin
    int d, sum, g0, r0;
    ref_pps = 0; trk_en = 1; ulk = 1; heat = 0; sel = 3'd0; rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R1 reg_en in reset", int'(reg_en_o), 0);
    chk("R1 lock in reset", int'(pps_lock_o), 0);
    chk("R1 realign in reset", int'(realign_o), 0);
    chk("R1 gate_vld in reset", int'(gate_vld_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3: not heated, good pulse train must not acquire
    repeat (4) slot(0, MINW);
    chk("R3 no realign while unheated", rcnt, 0);
    chk("R3 no regulator while unheated", int'(reg_en_o), 0);
    heat = 1;

    // R2: narrow pulse in the middle is ignored
    slot(0, MINW); slot(0, 2); slot(0, MINW);
    chk("R2 narrow pulse ignored", rcnt, 0);

    // R4: spacing SEC+3 and SEC-3 are outside the window
    slot(3, MINW); slot(0, MINW);
    chk("R4 out-of-window pair", rcnt, 0);
    slot(2, MINW);
    chk("R4 pair alone does not realign", rcnt, 0);
    slot(5, MINW);
    chk("R4 realign on pulse after pair", rcnt, 1);

    // R6: plausibility run, edges +-CRS included
    for (int k = 0; k < 16; k++) begin
      d = ((k * 5) % 21) - 10;
      slot(5 + d, MINW);
      if (k == 14) begin
        chk("R6 regulator off before last gate", int'(reg_en_o), 0);
        chk("R7 no gates during verify", gn, 0);
      end
    end
    chk("R6 regulator on after full run", int'(reg_en_o), 1);

    // R5 R7 R9: raw gates with lock build-up
    begin
      int ds [9] = '{3, -2, -1, 0, 1, 2, -3, 40, -15};
      for (int k = 0; k < 9; k++) begin
        g0 = gn;
        slot(5 + ds[k], MINW);
        chk("R7 one strobe per pulse", gn - g0, 1);
        chk("R5 gate equals pulse offset", gq[gn-1], ds[k]);
        if (k == 4) chk("R9 lock low before count", int'(pps_lock_o), 0);
        if (k == 5) chk("R9 lock after window run", int'(pps_lock_o), 1);
        if (k == 6) chk("R9 excursion clears lock", int'(pps_lock_o), 0);
      end
    end

    // R8: averaging over 16 and 128 pulses
    sel = 3'd1; sum = 0; g0 = gn;
    for (int k = 0; k < 16; k++) begin
      d = (k % 3) - 2; sum += d;
      slot(5 + d, MINW);
      if (k == 14) chk("R8 no strobe before 16", gn - g0, 0);
    end
    chk("R8 one strobe for 16", gn - g0, 1);
    chk("R8 floor mean of 16", gq[gn-1], floor_div(sum, 16));
    sel = 3'd2; sum = 0; g0 = gn;
    for (int k = 0; k < 128; k++) begin
      d = ((k * 5) % 11) - 6; sum += d;
      slot(5 + d, MINW);
    end
    chk("R8 one strobe for 128", gn - g0, 1);
    chk("R8 floor mean of 128", gq[gn-1], floor_div(sum, 128));
    sel = 3'd0;

    // R9 again, then R10 drop
    repeat (LCK) slot(5, MINW);
    chk("R9 lock on centered run", int'(pps_lock_o), 1);
    @(negedge clk); ulk = 0;
    @(negedge clk);
    chk("R10 regulator off after drop", int'(reg_en_o), 0);
    chk("R10 lock off after drop", int'(pps_lock_o), 0);
    ulk = 1;
    r0 = rcnt;
    slot(5, MINW); slot(5, MINW);
    chk("R10 restart needs new pair", rcnt - r0, 0);
    slot(5, MINW);
    chk("R10 reacquire realign", rcnt - r0, 1);

    // R6 failure path: gate of CRS+1 returns to search
    repeat (3) slot(5, MINW);
    slot(5 + CRS + 1, MINW);
    chk("R6 regulator off after bad gate", int'(reg_en_o), 0);
    r0 = rcnt;
    slot(5 + CRS + 1, MINW);
    chk("R6 failing pulse starts pair", rcnt - r0, 0);
    slot(5, MINW);
    chk("R6 realign after failure", rcnt - r0, 1);
    repeat (16) slot(5, MINW);
    chk("R6 tracking after second run", int'(reg_en_o), 1);

    finish_run();
  end
endmodule